// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and date in packed BCD. It holds seconds, minutes, hours, day of week, day of month, month and a two-digit year for the years 2000 to 2099. A free-running timebase pulse `tick_i` drives a sub-second prescaler. Once `TICKS_PER_SEC` pulses have been counted, the time advances by one second. When `TICKS_PER_SEC` is 1, the input can be a one-pulse-per-second signal.

The seconds ripple into minutes, hours, the day counters, the month and the year. Month lengths and leap years are handled in the counter. The hour byte supports a 24-hour format and a 12-hour format with an AM/PM flag.

Software or a neighbouring block loads any register through a single-cycle write port and reads any register through a combinational read port. A control register holds two bits. The first halts the timebase. The second write-protects the seven time registers. The seven values are also exposed on dedicated outputs, together with a one-cycle strobe that marks each new second.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour format), day of week 0x01, day of month 0x01, month 0x01, year 0x00 and control 0x00.
- R2: Seconds advance by one BCD step on the cycle after the TICKS_PER_SEC-th counted tick, and `sec_strobe_o` is high for exactly that one cycle. Seconds 0x59 wraps to 0x00 and carries into minutes. Minutes 0x59 wraps to 0x00 and carries into hours.
- R3: Hour bit 6 clear selects 24-hour format. Bits 5:0 hold BCD 00 to 23, and 0x23 wraps to 0x00 with a carry into the day counters.
- R4: Hour bit 6 set selects 12-hour format. Bit 5 is the PM flag and bits 4:0 hold BCD 01 to 12. Hour 11 steps to 12 and inverts the PM flag. Hour 12 steps to 01 with the flag unchanged. The carry into the day counters happens only on the step from 11 PM to 12 AM.
- R5: Day of week counts 1 to 7 on each day carry, and 7 wraps to 1.
- R6: Day of month wraps to 0x01 and carries into the month after its last day. Months 0x04, 0x06, 0x09 and 0x11 end at 0x30. Month 0x02 ends at 0x29 when the year value is divisible by 4 (year 0x00 included) and at 0x28 otherwise. All other months end at 0x31.
- R7: Month 0x12 wraps to 0x01 with a carry into the year, and year 0x99 wraps to 0x00.
- R8: Control register address 7, bit 7 is an active-low oscillator enable. While it is 1, ticks are not counted, the time does not advance and no strobe occurs.
- R9: Control bit 6 is write protect. While it is 1, writes to addresses 0 to 6 are ignored, and the control register itself stays writable.
- R10: An accepted write to address a (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 control) takes effect at the next edge. It also clears the prescaler, so the next advance needs TICKS_PER_SEC further ticks. A tick that arrives in the same cycle as the write causes no advance.
- R11: `rd_data_o` combinationally returns the register at `rd_addr_i`. Address 7 returns the control bits 7:6, with bits 5:0 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte with format and PM bits |
| wday_o | output | 8 | Day of week, 1 to 7 |
| mday_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year within the century, BCD |
| sec_strobe_o | output | 1 | One-cycle pulse on each advance |

## Verification
A register write and the final prescaler tick of a second can land on the same clock edge, and the block must let the write win. The bench provokes this by driving the counting tick together with a seconds write in one cycle. It then checks that the seconds hold exactly the written value, that no strobe appears, and that a full TICKS_PER_SEC ticks are needed before the next step. A similar collision happens when a protected write coincides with an advance. There, the seconds may move only by the advance, never to the written value.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_time_t;

  localparam logic [2:0] ADDR_CTL = 3'd7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of month in BCD; leap = (10*tens + units) mod 4 == 0
  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
    logic [3:0] rem;
    rem = ({3'd0, yr[4]} << 1) + yr[3:0];
    if (mon == 8'h02) return (rem[1:0] == 2'd0) ? 8'h29 : 8'h28;
    if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) return 8'h30;
    return 8'h31;
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic fire_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = run_i & tick_i & ~clr_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/cal_tod_next.sv
module cal_tod_next (
  input  logic [7:0] sec_i,
  input  logic [7:0] min_i,
  input  logic [7:0] hr_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic       day_carry_o
);
  import cal_pkg::*;

  logic sec_wrap, min_wrap;

  always_comb begin
    sec_wrap    = (sec_i == 8'h59);
    min_wrap    = sec_wrap && (min_i == 8'h59);
    sec_o       = sec_wrap ? 8'h00 : bcd_inc(sec_i);
    min_o       = min_i;
    hr_o        = hr_i;
    day_carry_o = 1'b0;
    if (sec_wrap) min_o = (min_i == 8'h59) ? 8'h00 : bcd_inc(min_i);
    if (min_wrap) begin
      if (hr_i[6]) begin
        // 12-hour: 11 -> 12 flips PM, 12 -> 01 keeps it
        if (hr_i[4:0] == 5'h12) begin
          hr_o = {2'b01, hr_i[5], 5'h01};
        end else if (hr_i[4:0] == 5'h11) begin
          hr_o        = {2'b01, ~hr_i[5], 5'h12};
          day_carry_o = hr_i[5];
        end else begin
          hr_o = {2'b01, hr_i[5], bcd_inc({3'b000, hr_i[4:0]})[4:0]};
        end
      end else if (hr_i[5:0] == 6'h23) begin
        hr_o        = 8'h00;
        day_carry_o = 1'b1;
      end else begin
        hr_o = {2'b00, bcd_inc({2'b00, hr_i[5:0]})[5:0]};
      end
    end
  end
endmodule

// File: rtl/cal_date_next.sv
module cal_date_next (
  input  logic       carry_i,
  input  logic [7:0] wday_i,
  input  logic [7:0] mday_i,
  input  logic [7:0] mon_i,
  input  logic [7:0] yr_i,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o
);
  import cal_pkg::*;

  logic mday_wrap, mon_wrap;

  always_comb begin
    wday_o    = wday_i;
    mday_o    = mday_i;
    mon_o     = mon_i;
    yr_o      = yr_i;
    mday_wrap = carry_i && (mday_i == month_end(mon_i, yr_i));
    mon_wrap  = mday_wrap && (mon_i == 8'h12);
    if (carry_i) begin
      wday_o = (wday_i == 8'h07) ? 8'h01 : bcd_inc(wday_i);
      mday_o = mday_wrap ? 8'h01 : bcd_inc(mday_i);
    end
    if (mday_wrap) mon_o = mon_wrap ? 8'h01 : bcd_inc(mon_i);
    if (mon_wrap)  yr_o  = (yr_i == 8'h99) ? 8'h00 : bcd_inc(yr_i);
  end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sec_strobe_o
);
  import cal_pkg::*;

  cal_time_t  t_q, t_nx;
  logic [1:0] ctl_q;   // [1] halt (active-low osc enable), [0] write protect
  logic       strobe_q;
  logic       wr_time, wr_ctl, adv, day_carry;

  assign wr_ctl  = wr_en_i && (wr_addr_i == ADDR_CTL);
  assign wr_time = wr_en_i && (wr_addr_i != ADDR_CTL) && !ctl_q[0];

  cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!ctl_q[1]),
    .tick_i (tick_i),
    .clr_i  (wr_time || wr_ctl),
    .fire_o (adv)
  );

  cal_tod_next u_tod (
    .sec_i       (t_q.sec),
    .min_i       (t_q.min),
    .hr_i        (t_q.hr),
    .sec_o       (t_nx.sec),
    .min_o       (t_nx.min),
    .hr_o        (t_nx.hr),
    .day_carry_o (day_carry)
  );

  cal_date_next u_date (
    .carry_i (day_carry),
    .wday_i  (t_q.wday),
    .mday_i  (t_q.mday),
    .mon_i   (t_q.mon),
    .yr_i    (t_q.yr),
    .wday_o  (t_nx.wday),
    .mday_o  (t_nx.mday),
    .mon_o   (t_nx.mon),
    .yr_o    (t_nx.yr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q      <= '{yr: 8'h00, mon: 8'h01, mday: 8'h01, wday: 8'h01,
                    hr: 8'h00, min: 8'h00, sec: 8'h00};
      ctl_q    <= 2'b00;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= adv;
      if (wr_ctl) ctl_q <= wr_data_i[7:6];
      if (wr_time) begin
        unique case (wr_addr_i)
          3'd0:    t_q.sec  <= wr_data_i;
          3'd1:    t_q.min  <= wr_data_i;
          3'd2:    t_q.hr   <= wr_data_i;
          3'd3:    t_q.wday <= wr_data_i;
          3'd4:    t_q.mday <= wr_data_i;
          3'd5:    t_q.mon  <= wr_data_i;
          default: t_q.yr   <= wr_data_i;
        endcase
      end else if (adv) begin
        t_q <= t_nx;
      end
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      3'd0:    rd_data_o = t_q.sec;
      3'd1:    rd_data_o = t_q.min;
      3'd2:    rd_data_o = t_q.hr;
      3'd3:    rd_data_o = t_q.wday;
      3'd4:    rd_data_o = t_q.mday;
      3'd5:    rd_data_o = t_q.mon;
      3'd6:    rd_data_o = t_q.yr;
      default: rd_data_o = {ctl_q, 6'd0};
    endcase
  end

  assign sec_o        = t_q.sec;
  assign min_o        = t_q.min;
  assign hour_o       = t_q.hr;
  assign wday_o       = t_q.wday;
  assign mday_o       = t_q.mday;
  assign month_o      = t_q.mon;
  assign year_o       = t_q.yr;
  assign sec_strobe_o = strobe_q;
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic [1:0] ctl_i,
  input logic [7:0] sec_i,
  input logic       strobe_i
);
  p_strobe_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> ($past(tick_i) && sec_i != $past(sec_i)));

  p_halt_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i[1] && !wr_en_i) |=> ($stable(sec_i) && !strobe_i));

  p_protect_ignores_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i[0] && wr_en_i && wr_addr_i != 3'd7) |=> (sec_i == $past(sec_i) || strobe_i));

  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !ctl_i[0] && wr_addr_i == 3'd0) |=> (sec_i == $past(wr_data_i) && !strobe_i));

  p_ctl_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd7) |=> (ctl_i == $past(wr_data_i[7:6])));
endmodule

bind bcd_calendar_clock cal_clock_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .ctl_i     (ctl_q),
  .sec_i     (sec_o),
  .strobe_i  (sec_strobe_o)
);

// File: tb/sim_bcd_calendar_clock.sv
module sim_bcd_calendar_clock;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data, sec, min, hour, wday, mday, month, year;
  logic       strobe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bcd_calendar_clock #(.TICKS_PER_SEC(TPS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sec_o(sec), .min_o(min), .hour_o(hour), .wday_o(wday),
    .mday_o(mday), .month_o(month), .year_o(year), .sec_strobe_o(strobe)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    logic [7:0] exp [8] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1/R11", $sformatf("reset reg %0d", a), v, exp[a]);
    end
    chk("R1", "reset strobe", {7'd0, strobe}, 8'h00);
  endtask

  task automatic t_seconds();
    ticks(TPS - 1);
    chk("R2", "sec before last tick", sec, 8'h00);
    chk("R2", "no strobe early", {7'd0, strobe}, 8'h00);
    ticks(1);
    chk("R2", "sec after full count", sec, 8'h01);
    chk("R2", "strobe on advance", {7'd0, strobe}, 8'h01);
    @(negedge clk);
    chk("R2", "strobe one cycle", {7'd0, strobe}, 8'h00);
    wr(3'd0, 8'h09);
    ticks(TPS);
    chk("R2", "sec 09->10", sec, 8'h10);
  endtask

  task automatic t_full_rollover();
    wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h23); wr(3'd3, 8'h07);
    wr(3'd4, 8'h31); wr(3'd5, 8'h12); wr(3'd6, 8'h99);
    ticks(TPS);
    chk("R2", "sec wrap", sec, 8'h00);
    chk("R2", "min wrap", min, 8'h00);
    chk("R3", "hour 23->00", hour, 8'h00);
    chk("R5", "wday 7->1", wday, 8'h01);
    chk("R6", "mday 31->01", mday, 8'h01);
    chk("R7", "month 12->01", month, 8'h01);
    chk("R7", "year 99->00", year, 8'h00);
  endtask

  task automatic t_twelve_hour();
    wr(3'd3, 8'h02);
    wr(3'd2, 8'h51); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(TPS);
    chk("R4", "11AM->12PM", hour, 8'h72);
    chk("R4", "no day carry at noon", wday, 8'h02);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(TPS);
    chk("R4", "12PM->01PM", hour, 8'h61);
    wr(3'd2, 8'h71); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(TPS);
    chk("R4", "11PM->12AM", hour, 8'h52);
    chk("R4", "day carry at midnight", wday, 8'h03);
    wr(3'd2, 8'h49); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(TPS);
    chk("R4", "09AM->10AM", hour, 8'h50);
  endtask

  task automatic roll_day(input logic [7:0] y, input logic [7:0] m, input logic [7:0] d,
                          input logic [7:0] exp_d, input logic [7:0] exp_m, input string what);
    wr(3'd6, y); wr(3'd5, m); wr(3'd4, d);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(TPS);
    chk("R6", {what, " mday"}, mday, exp_d);
    chk("R6", {what, " month"}, month, exp_m);
  endtask

  task automatic t_month_lengths();
    roll_day(8'h24, 8'h02, 8'h28, 8'h29, 8'h02, "leap feb 28");
    roll_day(8'h24, 8'h02, 8'h29, 8'h01, 8'h03, "leap feb 29");
    roll_day(8'h23, 8'h02, 8'h28, 8'h01, 8'h03, "plain feb 28");
    roll_day(8'h00, 8'h02, 8'h28, 8'h29, 8'h02, "year 00 feb 28");
    roll_day(8'h10, 8'h02, 8'h28, 8'h01, 8'h03, "year 10 feb 28");
    roll_day(8'h23, 8'h04, 8'h30, 8'h01, 8'h05, "april 30");
    roll_day(8'h23, 8'h11, 8'h30, 8'h01, 8'h12, "november 30");
    roll_day(8'h23, 8'h01, 8'h30, 8'h31, 8'h01, "january 30");
    roll_day(8'h23, 8'h07, 8'h31, 8'h01, 8'h08, "july 31");
  endtask

  task automatic t_halt();
    wr(3'd7, 8'h80);
    wr(3'd0, 8'h12);
    ticks(2 * TPS);
    chk("R8", "halted sec", sec, 8'h12);
    chk("R8", "halted strobe", {7'd0, strobe}, 8'h00);
    wr(3'd7, 8'h00);
    ticks(TPS);
    chk("R8", "resumed sec", sec, 8'h13);
  endtask

  task automatic t_protect();
    logic [7:0] v;
    wr(3'd0, 8'h10);
    wr(3'd7, 8'h40);
    wr(3'd0, 8'h33);
    wr(3'd6, 8'h55);
    chk("R9", "protected sec", sec, 8'h10);
    chk("R9", "protected year", year, 8'h23);
    rd(3'd7, v);
    chk("R9", "ctl readback", v, 8'h40);
    wr(3'd7, 8'h00);
    wr(3'd0, 8'h33);
    chk("R9", "unprotected sec", sec, 8'h33);
  endtask

  task automatic t_write_clears();
    wr(3'd0, 8'h05);
    ticks(2);
    wr(3'd0, 8'h20);
    ticks(TPS - 1);
    chk("R10", "prescaler cleared", sec, 8'h20);
    ticks(1);
    chk("R10", "advance after full count", sec, 8'h21);
    ticks(TPS - 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h40; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R10", "write beats tick", sec, 8'h40);
    chk("R10", "no strobe on write", {7'd0, strobe}, 8'h00);
    ticks(TPS - 1);
    chk("R10", "count restarted", sec, 8'h40);
    ticks(1);
    chk("R10", "next advance", sec, 8'h41);
  endtask

  task automatic t_read_port();
    logic [7:0] v;
    wr(3'd7, 8'hFF);
    rd(3'd7, v);
    chk("R11", "ctl low bits zero", v, 8'hC0);
    rd(3'd0, v);
    chk("R11", "read sec", v, sec);
    wr(3'd7, 8'h00);
    rd(3'd7, v);
    chk("R11", "ctl cleared", v, 8'h00);
  endtask

  initial begin
    #500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_seconds();
    t_full_rollover();
    t_twelve_hour();
    t_month_lengths();
    t_halt();
    t_protect();
    t_write_clears();
    t_read_port();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule